// File: doc/BRIEF.md
# Two-Level Region Address Translator

This block maps a 32-bit virtual address to a 30-bit physical address for a CPU that splits its address space into a process half and a system half. The top two address bits select the region. Region 0 is the lower process region, which grows up from address zero. Region 1 is the upper process region, which grows down toward its own start. Region 2 holds the system space. Region 3 is reserved. Each valid region has its own page-table base and length input. The system table sits at a physical address. The two process tables sit in system virtual space, so a process lookup first resolves the address of its own table entry through the system table.

One request is handled at a time. The CPU side presents an address, a privilege mode and a read/write flag. The block then issues one or two reads on a single-outstanding memory port to fetch table entries. It answers with a status code, a flag that marks a fault raised during the nested table fetch, and, on success, the physical address. Pages are 512 bytes, and the low 9 address bits pass through unchanged.

Top module: `vaddr_xlate`

## Requirements
- R1: Bits 31:30 of the virtual address select the region: 0 lower process, 1 upper process, 2 system, 3 reserved. A region 3 request answers status 4 with the table-fetch flag clear and makes no memory read.
- R2: In region 0, a page number (bits 29:9) is legal only when it is below `p0_len`. Otherwise the answer is status 1 with the flag clear and no memory read.
- R3: In region 1, a page number is legal only when it is at or above `p1_len`. Otherwise the answer is status 1 with the flag clear and no memory read.
- R4: In region 2, a page number is legal only when it is below `sys_len`, else status 1. The entry is read from physical address `sys_base + 4*page`.
- R5: A process entry lives at system virtual address `base + 4*page`. That address is translated through the system table before the entry is read. If that address is not in region 2, the answer is status 4. If it fails the system length check, the answer is status 1. If its system entry is invalid, the answer is status 3. Each of these answers sets the table-fetch flag.
- R6: An entry holds a valid bit at bit 31, a protection code at bits 30:27 and a frame number at bits 20:0. A successful answer is status 0 with the physical address `{frame, offset}`.
- R7: Modes are encoded 0 kernel, 1 executive, 2 supervisor, 3 user. A read is allowed when the mode is at most entry bits 28:27. A write is allowed when the mode is at most entry bits 30:29. A refusal answers status 2. Protection is checked before the valid bit, and a permitted but invalid entry answers status 3. The nested system fetch is a kernel read and ignores protection.
- R8: `req_ready` is high only when no request is in flight. A response holds its status, flag and address until `rsp_ready`. Every faulting response carries a physical address of zero.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, and read data is taken in the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_mode | input | 2 | Privilege mode of the access |
| sys_base | input | 30 | Physical base of the system table |
| sys_len | input | 22 | System table length in entries |
| p0_base | input | 32 | System-virtual base of the region 0 table |
| p0_len | input | 22 | Region 0 length limit |
| p1_base | input | 32 | System-virtual base of the region 1 table |
| p1_len | input | 22 | Region 1 lower page bound |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 3 | 0 ok, 1 length, 2 access, 3 not valid, 4 reserved |
| rsp_pt_fault | output | 1 | Fault raised while fetching the process table entry |
| rsp_paddr | output | 30 | Physical address, zero on fault |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | 30 | Physical address of the entry read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
A wrong control state shows up at the ports as a wrong number of memory reads within one request. A length or reserved fault must produce none. A system lookup must produce one read, and a process lookup must produce two. A stale latched entry address or offset shows up in the very next response as a wrong physical address or a wrong status. The sweeps compare every response against a model of the table contents and count the reads in each transaction, so a misrouted state is caught in the request that misroutes it.

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int OFF_W = 9,
  parameter int PA_W = 30,
  localparam int VPN_W = 30 - OFF_W,
  localparam int LEN_W = VPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  input  logic [1:0]       req_mode,
  input  logic [PA_W-1:0]  sys_base,
  input  logic [LEN_W-1:0] sys_len,
  input  logic [31:0]      p0_base,
  input  logic [LEN_W-1:0] p0_len,
  input  logic [31:0]      p1_base,
  input  logic [LEN_W-1:0] p1_len,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [2:0]       rsp_status,
  output logic             rsp_pt_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata
);
  localparam int PFN_W = PA_W - OFF_W;
  localparam logic [2:0] ST_OK = 3'd0, ST_LEN = 3'd1, ST_ACV = 3'd2,
                         ST_TNV = 3'd3, ST_RSV = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_SPTE, S_PTE, S_RSP} st_t;
  st_t state;

  logic [1:0]       mode_q;
  logic             wr_q;
  logic [OFF_W-1:0] off_q, pt_off_q;
  logic [PA_W-1:0]  addr_q, paddr_q;
  logic [2:0]       status_q;
  logic             flag_q;

  wire [1:0]       rgn    = req_vaddr[31:30];
  wire [VPN_W-1:0] vpn    = req_vaddr[29:OFF_W];
  wire [31:0]      pt_va  = (rgn[0] ? p1_base : p0_base) + 32'({vpn, 2'b00});
  wire [VPN_W-1:0] pt_vpn = pt_va[29:OFF_W];
  wire in_len = (rgn == 2'd1) ? ({1'b0, vpn} >= p1_len)
                              : ({1'b0, vpn} < (rgn[1] ? sys_len : p0_len));
  wire pt_len_ok = {1'b0, pt_vpn} < sys_len;

  wire [PA_W-1:0] sys_ent  = sys_base + {{(PA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
  wire [PA_W-1:0] pt_ent   = sys_base + {{(PA_W-VPN_W-2){1'b0}}, pt_vpn, 2'b00};

  wire             pte_v   = mem_rdata[31];
  wire [3:0]       pte_pr  = mem_rdata[30:27];
  wire [PFN_W-1:0] pte_pfn = mem_rdata[PFN_W-1:0];
  wire [1:0]       lim     = wr_q ? pte_pr[3:2] : pte_pr[1:0];
  wire             allowed = mode_q <= lim;

  assign req_ready    = (state == S_IDLE);
  assign rsp_valid    = (state == S_RSP);
  assign mem_req      = (state == S_SPTE) || (state == S_PTE);
  assign mem_addr     = addr_q;
  assign rsp_status   = status_q;
  assign rsp_pt_fault = flag_q;
  assign rsp_paddr    = paddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= '0;
      wr_q     <= 1'b0;
      off_q    <= '0;
      pt_off_q <= '0;
      addr_q   <= '0;
      paddr_q  <= '0;
      status_q <= ST_OK;
      flag_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          mode_q   <= req_mode;
          wr_q     <= req_write;
          off_q    <= req_vaddr[OFF_W-1:0];
          pt_off_q <= pt_va[OFF_W-1:0];
          paddr_q  <= '0;
          flag_q   <= 1'b0;
          if (rgn == 2'd3) begin
            status_q <= ST_RSV;
            state    <= S_RSP;
          end else if (!in_len) begin
            status_q <= ST_LEN;
            state    <= S_RSP;
          end else if (rgn == 2'd2) begin
            addr_q <= sys_ent;
            state  <= S_PTE;
          end else if (pt_va[31:30] != 2'd2) begin
            status_q <= ST_RSV;
            flag_q   <= 1'b1;
            state    <= S_RSP;
          end else if (!pt_len_ok) begin
            status_q <= ST_LEN;
            flag_q   <= 1'b1;
            state    <= S_RSP;
          end else begin
            addr_q <= pt_ent;
            state  <= S_SPTE;
          end
        end
        S_SPTE: if (mem_ack) begin
          if (!pte_v) begin
            status_q <= ST_TNV;
            flag_q   <= 1'b1;
            state    <= S_RSP;
          end else begin
            addr_q <= {pte_pfn, pt_off_q};
            state  <= S_PTE;
          end
        end
        S_PTE: if (mem_ack) begin
          state <= S_RSP;
          if (!allowed) status_q <= ST_ACV;
          else if (!pte_v) status_q <= ST_TNV;
          else begin
            status_q <= ST_OK;
            paddr_q  <= {pte_pfn, off_q};
          end
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  a_r1_reserved_region: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_vaddr[31:30] == 2'd3 |=>
      rsp_valid && rsp_status == ST_RSV && !rsp_pt_fault);

  a_r2_low_region_limit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_vaddr[31:30] == 2'd0 &&
      {1'b0, req_vaddr[29:OFF_W]} >= p0_len |=>
      rsp_valid && rsp_status == ST_LEN && !rsp_pt_fault);

  a_r3_high_region_limit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_vaddr[31:30] == 2'd1 &&
      {1'b0, req_vaddr[29:OFF_W]} < p1_len |=>
      rsp_valid && rsp_status == ST_LEN && !rsp_pt_fault);

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) &&
      $stable(rsp_paddr) && $stable(rsp_pt_fault));

  a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != ST_OK |-> rsp_paddr == '0);

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);
endmodule

// File: tb/vaddr_xlate_bench.sv
module vaddr_xlate_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_mode = '0;
  logic [29:0] sys_base = 30'h1000;
  logic [21:0] sys_len = 22'd8, p0_len = 22'd6, p1_len = 22'h1FFFF8;
  logic [31:0] p0_base = 32'h8000_0400, p1_base = 32'h8000_0600 - 32'h007F_FFC0;
  logic req_ready, rsp_valid, rsp_pt_fault, mem_req;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [2:0] rsp_status;
  logic [29:0] rsp_paddr, mem_addr;
  int total = 0, bad = 0, reads = 0, cycles = 0, wait_n = 0;
  bit timeout = 0;

  vaddr_xlate u_vaddr_xlate (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] memf(logic [29:0] a);
    logic [29:0] i;
    logic [20:0] f;
    logic [6:0] k;
    if (a >= sys_base && a < sys_base + 30'd64) begin
      i = (a - sys_base) >> 2;
      return {i != 30'd5, i[3:0], 6'b0, 21'(30'h100 + i)};
    end
    f = a[29:9];
    k = a[8:2];
    return {(k % 5) != 4, k[3:0] ^ f[3:0], 6'b0, 21'({f[11:0], k}) + 21'h40};
  endfunction

  task automatic model(input logic [31:0] va, input logic [1:0] md, input logic wr,
                       output logic [2:0] st, output logic fl, output logic [29:0] pa,
                       output int nr);
    logic [20:0] vpn = va[29:9];
    logic [31:0] ptva, pte, spte;
    logic [29:0] ent;
    logic [1:0] lim;
    st = 0; fl = 0; pa = 0; nr = 0;
    if (va[31:30] == 2'd3) begin st = 4; return; end
    if (va[31:30] == 2'd2) begin
      if ({1'b0, vpn} >= sys_len) begin st = 1; return; end
      ent = sys_base + 30'({vpn, 2'b00});
    end else begin
      if (va[31:30] == 2'd0 && {1'b0, vpn} >= p0_len) begin st = 1; return; end
      if (va[31:30] == 2'd1 && {1'b0, vpn} < p1_len) begin st = 1; return; end
      ptva = (va[30] ? p1_base : p0_base) + 32'({vpn, 2'b00});
      if (ptva[31:30] != 2'd2) begin st = 4; fl = 1; return; end
      if ({1'b0, ptva[29:9]} >= sys_len) begin st = 1; fl = 1; return; end
      spte = memf(sys_base + 30'({ptva[29:9], 2'b00}));
      nr = 1;
      if (!spte[31]) begin st = 3; fl = 1; return; end
      ent = {spte[20:0], ptva[8:0]};
    end
    pte = memf(ent);
    nr = nr + 1;
    lim = wr ? pte[30:29] : pte[28:27];
    if (md > lim) st = 2;
    else if (!pte[31]) st = 3;
    else pa = {pte[20:0], va[8:0]};
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder with varying latency
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_n == 0) begin
        mem_ack = 1'b1;
        mem_rdata = memf(mem_addr);
        reads++;
        wait_n = reads % 3;
      end else wait_n--;
    end
  end

  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 150000) timeout = 1;
  end

  task automatic run(input logic [31:0] va, input logic [1:0] md, input logic wr, input string tag);
    logic [2:0] st; logic fl; logic [29:0] pa; int nr, r0;
    model(va, md, wr, st, fl, pa, nr);
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_mode = md; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && !timeout) @(negedge clk);
    if (timeout) return;
    @(negedge clk);
    chk(rsp_valid, {tag, " R8 hold"}, 32'(rsp_valid), 1);
    chk(rsp_status == st, {tag, " status"}, 32'(rsp_status), 32'(st));
    chk(rsp_pt_fault == fl, {tag, " R5 table-fetch flag"}, 32'(rsp_pt_fault), 32'(fl));
    chk(rsp_paddr == pa, {tag, " R6 paddr"}, 32'(rsp_paddr), 32'(pa));
    chk(reads - r0 == nr, {tag, " R9 read count"}, 32'(reads - r0), 32'(nr));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready, {tag, " R8 ready after take"}, 32'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R8 reset state",
        {29'd0, req_ready, rsp_valid, mem_req}, 32'b100);
    rst_n = 1'b1;
    for (int v = 0; v < 10; v++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          run({2'd0, 21'(v), 9'(v * 37)}, 2'(m), 1'(w), "R2 R7 low region");
    for (int v = 0; v < 12; v++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          run({2'd1, 21'h1FFFF4 + 21'(v), 9'(v * 53)}, 2'(m), 1'(w), "R3 R7 high region");
    run({2'd1, 21'd0, 9'd5}, 2'd0, 1'b0, "R3 high region page zero");
    for (int v = 0; v < 10; v++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          run({2'd2, 21'(v), 9'(v * 11)}, 2'(m), 1'(w), "R4 R6 system region");
    for (int v = 0; v < 3; v++)
      run({2'd3, 21'(v), 9'd1}, 2'(v), 1'b0, "R1 reserved region");
    p0_base = 32'h8000_0A00;
    for (int v = 0; v < 2; v++) run({2'd0, 21'(v), 9'd3}, 2'd0, 1'b0, "R5 invalid system entry");
    p0_base = 32'h8000_1200;
    for (int v = 0; v < 2; v++) run({2'd0, 21'(v), 9'd3}, 2'd0, 1'b0, "R5 system length");
    p0_base = 32'h0000_0400;
    for (int v = 0; v < 2; v++) run({2'd0, 21'(v), 9'd3}, 2'd0, 1'b0, "R5 table outside system");
    if (timeout) chk(0, "watchdog", 32'(cycles), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule